// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block shifts or rotates the second operand of a 32-bit RISC datapath and produces the shifter carry-out that a flag-setting ALU operation consumes. It takes one operand word, a two-bit shift type, the current carry flag, and a mode select. The mode select decides where the shift distance comes from. In immediate mode the distance is a 5-bit instruction field. In register mode it is an 8-bit value read from a register.

The two modes treat edge distances differently. In immediate mode a zero field is reinterpreted for the right shifts as a full-width shift, and for rotate as a one-bit rotate through carry. In register mode a zero distance passes the operand through unchanged. Register distances of 32 and above follow their own saturation rules.

The shift network is purely combinational. A parameter selects whether one output register stage follows it (default) or whether the outputs are taken straight from the logic.

Top module: `barrel_shift_unit`

## Requirements
- R1: Shift type codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. For a distance n from 1 to 31 in either mode, the result is the operand shifted or rotated by n according to that code.
- R2: For a distance n from 1 to 31, the carry-out is the last bit moved out of the word: operand bit 32-n for logical left, and operand bit n-1 for the two right shifts and for rotate.
- R3: Immediate mode, logical right, field 0: the result is all zeros and the carry-out is operand bit 31.
- R4: Immediate mode, arithmetic right, field 0: every result bit equals operand bit 31, and the carry-out is operand bit 31.
- R5: Immediate mode, rotate right, field 0: the result is the carry input followed by operand bits 31 down to 1, and the carry-out is operand bit 0.
- R6: Immediate mode, logical left, field 0: the result is the operand unchanged and the carry-out equals the carry input.
- R7: Register mode, distance 0, any type: the result is the operand unchanged and the carry-out equals the carry input.
- R8: Register mode, logical left or logical right, distance 32 or more: the result is zero. At exactly 32 the carry-out is operand bit 0 for left and operand bit 31 for right. Above 32 the carry-out is 0.
- R9: Register mode, arithmetic right, distance 32 or more: the result is filled with operand bit 31, and the carry-out is operand bit 31.
- R10: Register mode, rotate right, uses the distance modulo 32. A nonzero multiple of 32 returns the operand unchanged with carry-out equal to operand bit 31.
- R11: The register distance is 8 bits wide, so every value from 0 to 255 is honoured, including those at 128 and above.
- R12: With the output stage enabled, each result and carry-out appears one clock after its inputs. While reset is asserted, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous reset, active low |
| operandIn | input | 32 | Word to shift |
| shiftType | input | 2 | Shift type code (see R1) |
| regMode | input | 1 | 1 = distance from regAmt, 0 = distance from immAmt |
| immAmt | input | 5 | Distance field used in immediate mode |
| regAmt | input | 8 | Distance value used in register mode |
| carryIn | input | 1 | Current carry flag |
| resultOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The assertions assume that every input is a known value at each rising clock edge after reset, and that the distance input not selected by regMode has no effect. Each check compares the registered outputs with the inputs captured on the previous edge, so it relies on the inputs staying stable for the whole cycle. The stimulus meets these assumptions by changing inputs only on falling edges and by always driving both distance inputs to defined values. The unused distance input is deliberately given nonzero garbage, which shows whether it leaks into the result.

// File: rtl/barrel_shift_pkg.sv
package barrel_shift_pkg;
  localparam int DATA_W    = 32;
  localparam int SH_W      = $clog2(DATA_W);
  localparam int REG_AMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shiftKind_e;

  typedef enum logic [1:0] {
    OP_PASS   = 2'd0,
    OP_NORMAL = 2'd1,
    OP_RRX    = 2'd2,
    OP_FULL   = 2'd3
  } opClass_e;

  typedef struct packed {
    opClass_e        opClass;
    logic            exactWidth;
    logic [SH_W-1:0] amt;
  } shiftStrobe_t;
endpackage

// File: rtl/barrel_shift_ctrl.sv
module barrel_shift_ctrl
  import barrel_shift_pkg::*;
(
  input  shiftKind_e           shType,
  input  logic                 regMode,
  input  logic [SH_W-1:0]      immAmt,
  input  logic [REG_AMT_W-1:0] regAmt,
  output shiftStrobe_t         strobe
);
  localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

  always_comb begin
    strobe = '{opClass: OP_PASS, exactWidth: 1'b0, amt: '0};
    if (!regMode) begin
      if (immAmt == '0) begin
        unique case (shType)
          SH_LSL: strobe.opClass = OP_PASS;
          SH_LSR, SH_ASR: begin
            strobe.opClass    = OP_FULL;
            strobe.exactWidth = 1'b1;
          end
          default: strobe.opClass = OP_RRX;
        endcase
      end else begin
        strobe.opClass = OP_NORMAL;
        strobe.amt     = immAmt;
      end
    end else if (regAmt != '0) begin
      if (shType == SH_ROR) begin
        if (regAmt[SH_W-1:0] == '0) begin
          strobe.opClass = OP_FULL;
        end else begin
          strobe.opClass = OP_NORMAL;
          strobe.amt     = regAmt[SH_W-1:0];
        end
      end else if (regAmt >= FULL_AMT) begin
        strobe.opClass    = OP_FULL;
        strobe.exactWidth = (regAmt == FULL_AMT);
      end else begin
        strobe.opClass = OP_NORMAL;
        strobe.amt     = regAmt[SH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/barrel_shift_datapath.sv
module barrel_shift_datapath
  import barrel_shift_pkg::*;
(
  input  logic [DATA_W-1:0] operand,
  input  shiftKind_e        shType,
  input  logic              carryIn,
  input  shiftStrobe_t      strobe,
  output logic [DATA_W-1:0] result,
  output logic              carry
);
  logic [DATA_W-1:0]   leftLast;
  logic [DATA_W-1:0]   rightLast;
  logic [2*DATA_W-1:0] doubled;
  logic [SH_W-1:0]     amtLess1;
  logic                msb;

  assign msb      = operand[DATA_W-1];
  assign amtLess1 = strobe.amt - 1'b1;
  assign doubled  = {operand, operand} >> strobe.amt;

  always_comb begin
    leftLast  = operand << amtLess1;
    rightLast = operand >> amtLess1;
    result    = operand;
    carry     = carryIn;
    unique case (strobe.opClass)
      OP_PASS: begin
        result = operand;
        carry  = carryIn;
      end
      OP_RRX: begin
        result = {carryIn, operand[DATA_W-1:1]};
        carry  = operand[0];
      end
      OP_FULL: begin
        unique case (shType)
          SH_LSL: begin
            result = '0;
            carry  = strobe.exactWidth & operand[0];
          end
          SH_LSR: begin
            result = '0;
            carry  = strobe.exactWidth & msb;
          end
          SH_ASR: begin
            result = {DATA_W{msb}};
            carry  = msb;
          end
          default: begin
            result = operand;
            carry  = msb;
          end
        endcase
      end
      default: begin
        unique case (shType)
          SH_LSL: begin
            result = operand << strobe.amt;
            carry  = leftLast[DATA_W-1];
          end
          SH_LSR: begin
            result = operand >> strobe.amt;
            carry  = rightLast[0];
          end
          SH_ASR: begin
            result = DATA_W'($signed(operand) >>> strobe.amt);
            carry  = rightLast[0];
          end
          default: begin
            result = doubled[DATA_W-1:0];
            carry  = rightLast[0];
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import barrel_shift_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    operandIn,
  input  logic [1:0]           shiftType,
  input  logic                 regMode,
  input  logic [SH_W-1:0]      immAmt,
  input  logic [REG_AMT_W-1:0] regAmt,
  input  logic                 carryIn,
  output logic [DATA_W-1:0]    resultOut,
  output logic                 carryOut
);
  shiftStrobe_t      strobe;
  shiftKind_e        shType;
  logic [DATA_W-1:0] combResult;
  logic              combCarry;

  assign shType = shiftKind_e'(shiftType);

  barrel_shift_ctrl u_ctrl (
    .shType (shType),
    .regMode(regMode),
    .immAmt (immAmt),
    .regAmt (regAmt),
    .strobe (strobe)
  );

  barrel_shift_datapath u_dp (
    .operand(operandIn),
    .shType (shType),
    .carryIn(carryIn),
    .strobe (strobe),
    .result (combResult),
    .carry  (combCarry)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          resultOut <= '0;
          carryOut  <= 1'b0;
        end else begin
          resultOut <= combResult;
          carryOut  <= combCarry;
        end
      end
    end else begin : g_comb
      assign resultOut = combResult;
      assign carryOut  = combCarry;
    end
  endgenerate
endmodule

// File: rtl/barrel_shift_checker.sv
module barrel_shift_checker
  import barrel_shift_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [DATA_W-1:0]    operandIn,
  input logic [1:0]           shiftType,
  input logic                 regMode,
  input logic [SH_W-1:0]      immAmt,
  input logic [REG_AMT_W-1:0] regAmt,
  input logic                 carryIn,
  input logic [DATA_W-1:0]    resultOut,
  input logic                 carryOut
);
  logic                 pValid;
  logic [DATA_W-1:0]    pOp;
  logic [1:0]           pType;
  logic                 pRegMode;
  logic [SH_W-1:0]      pImm;
  logic [REG_AMT_W-1:0] pReg;
  logic                 pCin;

  generate
    if (OUT_REG) begin : g_cap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pValid   <= 1'b0;
          pOp      <= '0;
          pType    <= '0;
          pRegMode <= 1'b0;
          pImm     <= '0;
          pReg     <= '0;
          pCin     <= 1'b0;
        end else begin
          pValid   <= 1'b1;
          pOp      <= operandIn;
          pType    <= shiftType;
          pRegMode <= regMode;
          pImm     <= immAmt;
          pReg     <= regAmt;
          pCin     <= carryIn;
        end
      end
    end else begin : g_now
      assign pValid   = 1'b1;
      assign pOp      = operandIn;
      assign pType    = shiftType;
      assign pRegMode = regMode;
      assign pImm     = immAmt;
      assign pReg     = regAmt;
      assign pCin     = carryIn;
    end
  endgenerate

  a_r7_reg_zero_pass: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pRegMode && pReg == '0) |-> (resultOut == pOp && carryOut == pCin));

  a_r6_imm_left_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && !pRegMode && pType == 2'd0 && pImm == '0) |-> (resultOut == pOp && carryOut == pCin));

  a_r3_imm_right_zero: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && !pRegMode && pType == 2'd1 && pImm == '0) |-> (resultOut == '0 && carryOut == pOp[DATA_W-1]));

  a_r5_rotate_carry: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && !pRegMode && pType == 2'd3 && pImm == '0)
      |-> (resultOut == {pCin, pOp[DATA_W-1:1]} && carryOut == pOp[0]));

  a_r8_reg_logical_sat: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pRegMode && !pType[1] && pReg >= REG_AMT_W'(DATA_W)) |-> (resultOut == '0));

  a_r9_reg_arith_sat: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pRegMode && pType == 2'd2 && pReg >= REG_AMT_W'(DATA_W))
      |-> (resultOut == {DATA_W{pOp[DATA_W-1]}} && carryOut == pOp[DATA_W-1]));

  a_r10_reg_rotate_whole: assert property (@(posedge clk) disable iff (!rstN)
    (pValid && pRegMode && pType == 2'd3 && pReg != '0 && pReg[SH_W-1:0] == '0)
      |-> (resultOut == pOp && carryOut == pOp[DATA_W-1]));
endmodule

bind barrel_shift_unit barrel_shift_checker #(.OUT_REG(OUT_REG)) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .operandIn(operandIn),
  .shiftType(shiftType),
  .regMode  (regMode),
  .immAmt   (immAmt),
  .regAmt   (regAmt),
  .carryIn  (carryIn),
  .resultOut(resultOut),
  .carryOut (carryOut)
);

// File: tb/barrel_shift_unit_bench.sv
module barrel_shift_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operandIn = '0;
  logic [1:0]  shiftType = '0;
  logic        regMode = 1'b0;
  logic [4:0]  immAmt = '0;
  logic [7:0]  regAmt = '0;
  logic        carryIn = 1'b0;
  logic [31:0] resultOut;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        cy;
    string       tagR;
    string       tagC;
  } expItem_t;

  expItem_t sbQ[$];

  always #2 clk = ~clk;

  barrel_shift_unit u_barrel_shift_unit (
    .clk(clk), .rstN(rstN), .operandIn(operandIn), .shiftType(shiftType),
    .regMode(regMode), .immAmt(immAmt), .regAmt(regAmt), .carryIn(carryIn),
    .resultOut(resultOut), .carryOut(carryOut)
  );

  function automatic void plainShift(input logic [31:0] op, input logic [1:0] t, input int n,
                                     output logic [31:0] r, output logic c);
    case (t)
      2'd0: begin r = op << n; c = op[32-n]; end
      2'd1: begin r = op >> n; c = op[n-1]; end
      2'd2: begin r = 32'($signed(op) >>> n); c = op[n-1]; end
      default: begin r = (op >> n) | (op << (32 - n)); c = op[n-1]; end
    endcase
  endfunction

  function automatic void model(input logic [31:0] op, input logic [1:0] t, input logic rm,
                                input logic [4:0] ia, input logic [7:0] ra, input logic ci,
                                output expItem_t e);
    int a;
    e.tagR = "R1";
    e.tagC = "R2";
    if (!rm) begin
      if (ia == 0) begin
        case (t)
          2'd0: begin e.res = op; e.cy = ci; e.tagR = "R6"; e.tagC = "R6"; end
          2'd1: begin e.res = 0; e.cy = op[31]; e.tagR = "R3"; e.tagC = "R3"; end
          2'd2: begin e.res = {32{op[31]}}; e.cy = op[31]; e.tagR = "R4"; e.tagC = "R4"; end
          default: begin e.res = {ci, op[31:1]}; e.cy = op[0]; e.tagR = "R5"; e.tagC = "R5"; end
        endcase
      end else plainShift(op, t, int'(ia), e.res, e.cy);
    end else begin
      a = int'(ra);
      if (a == 0) begin
        e.res = op; e.cy = ci; e.tagR = "R7"; e.tagC = "R7";
      end else if (t == 2'd3) begin
        if (a % 32 == 0) begin
          e.res = op; e.cy = op[31]; e.tagR = "R10"; e.tagC = "R10";
        end else begin
          plainShift(op, t, a % 32, e.res, e.cy);
          if (a > 31) begin e.tagR = "R10"; e.tagC = "R10"; end
        end
      end else if (a >= 32) begin
        if (t == 2'd2) begin
          e.res = {32{op[31]}}; e.cy = op[31]; e.tagR = "R9"; e.tagC = "R9";
        end else begin
          e.res = 0;
          e.cy = (a == 32) ? ((t == 2'd0) ? op[0] : op[31]) : 1'b0;
          e.tagR = "R8"; e.tagC = "R8";
        end
      end else plainShift(op, t, a, e.res, e.cy);
      if (a >= 128) begin e.tagR = "R11"; e.tagC = "R11"; end
    end
  endfunction

  task automatic drive(input logic [31:0] op, input logic [1:0] t, input logic rm,
                       input logic [4:0] ia, input logic [7:0] ra, input logic ci);
    expItem_t e;
    @(negedge clk);
    operandIn = op; shiftType = t; regMode = rm; immAmt = ia; regAmt = ra; carryIn = ci;
    model(op, t, rm, ia, ra, ci, e);
    sbQ.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: an item pushed at a falling edge is registered at the next rising edge (R12)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN && sbQ.size() > 0) begin
        expItem_t e;
        e = sbQ.pop_front();
        check(resultOut === e.res, e.tagR, resultOut, e.res);
        check(carryOut === e.cy, e.tagC, 32'(carryOut), 32'(e.cy));
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    operandIn = 32'hDEAD_BEEF;
    carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check(resultOut === 32'h0, "R12", resultOut, 32'h0);
    check(carryOut === 1'b0, "R12", 32'(carryOut), 32'h0);
    rstN = 1'b1;

    // R6, R3, R4, R5: immediate field zero; the unused register distance is garbage
    for (int t = 0; t < 4; t++) begin
      drive(32'h8000_0001, 2'(t), 1'b0, 5'd0, 8'd77, 1'b1);
      drive(32'h7FFF_FFFE, 2'(t), 1'b0, 5'd0, 8'd0, 1'b0);
    end
    // R1, R2: immediate distances 1 and 31 and a middle one
    for (int t = 0; t < 4; t++) begin
      drive(32'hA5C3_0F96, 2'(t), 1'b0, 5'd1, 8'd200, 1'b0);
      drive(32'hA5C3_0F96, 2'(t), 1'b0, 5'd31, 8'd0, 1'b1);
      drive(32'h1357_9BDF, 2'(t), 1'b0, 5'd13, 8'd33, 1'b0);
    end
    // R7, R8, R9, R10, R11: register distance boundaries; immAmt is garbage
    for (int t = 0; t < 4; t++) begin
      drive(32'hC000_0003, 2'(t), 1'b1, 5'd9, 8'd0, 1'b1);
      drive(32'hC000_0003, 2'(t), 1'b1, 5'd9, 8'd31, 1'b0);
      drive(32'hC000_0003, 2'(t), 1'b1, 5'd0, 8'd32, 1'b0);
      drive(32'h4000_0002, 2'(t), 1'b1, 5'd0, 8'd32, 1'b1);
      drive(32'hC000_0003, 2'(t), 1'b1, 5'd3, 8'd33, 1'b0);
      drive(32'hC000_0003, 2'(t), 1'b1, 5'd3, 8'd64, 1'b0);
      drive(32'h8765_4321, 2'(t), 1'b1, 5'd0, 8'd128, 1'b0);
      drive(32'h8765_4321, 2'(t), 1'b1, 5'd0, 8'd255, 1'b1);
      drive(32'h8765_4321, 2'(t), 1'b1, 5'd0, 8'd37, 1'b0);
    end
    // Mixed patterns across every mode
    for (int i = 0; i < 400; i++) begin
      drive($urandom, 2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom), 1'($urandom));
    end
    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R12", 32'(sbQ.size()), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule